// File: doc/BRIEF.md
# Scan-Chain Bridge to an Internal Service Bus

This block is a test-data register with its own small controller. It lets a debugger reach a word-addressed internal service bus through a single JTAG instruction. A standard TAP controller sits in front of it. When the instruction register holds the code `10100`, the TAP asserts `sel` and passes its Capture-DR, Shift-DR and Update-DR strobes through as single-cycle pulses in the test-clock domain.

The register is 34 bits long. Each complete scan is read either as an address phase or as a data phase, and the meaning alternates between scans. An address scan names a 7-bit location and a direction. The data scan that follows either carries the word to write or brings back the word that was read. Two status bits, error and busy, come out with every scan.

In the address phase and the write phase they sit at the low end of the register. In the read phase they sit at the high end, above the 32 data bits, so a debugger can stop shifting as soon as it has the bits it needs. A scan that captured busy as set is void: the debugger simply repeats it. The block also supplies the 5-bit status pattern that the TAP loads on Capture-IR.

Top module: `svc_scan_reg`

## Requirements
- R1: `ir_cap` carries `{prot, error, busy, 0, 1}`, with `prot` in bit 4 and the constant 1 in bit 0.
- R2: After reset, and whenever `sel` is low, the register is in address mode, so the first scan after selection is an address phase.
- R3: Capture-DR loads the register according to the phase.
  - In the address phase and the write phase: bit 1 = error, bit 0 = busy, all other bits 0.
  - In the read phase: bit 33 = error, bit 32 = busy, bits 31:0 = the read word.
- R4: Shift-DR moves the register one place toward bit 0, with `tdi` entering bit 33. `tdo` always shows bit 0, so a capture followed by 34 shifts presents the captured word LSB first.
- R5: An Update-DR in address mode, from a scan that captured busy = 0, does three things:
  - latches bits 33:27 as the address;
  - latches bit 26 as the direction (1 = read, 0 = write);
  - switches the register to data mode.
- R6: For a read, `bus_rd` pulses for exactly one cycle, in the cycle after that address update, with `bus_addr` valid. The word returned with `bus_ack` is shown by the next read-data scan.
- R7: An Update-DR in write-data mode, from a scan that captured busy = 0, does two things:
  - pulses `bus_wr` for one cycle with `bus_wdata` = register bits 33:2;
  - returns the register to address mode.
- R8: Busy is set when a bus access is issued and stays set until `bus_ack`. An acknowledge with `bus_err` high sets the error flag, which stays set until the next accepted address update clears it.
- R9: An Update-DR that ends a scan whose capture saw busy = 1 has no effect: the mode does not change, the address does not change, and no bus strobe is issued.
- R10: A read-data scan cut short after fewer than 34 shifts still completes the phase, and the next scan is an address phase.
- R11: DR strobes that arrive while `sel` is low have no effect on the bus or on the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Instruction for this register is selected |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| prot | input | 1 | Protection flag reported in the IR capture |
| ir_cap | output | 5 | Pattern for Capture-IR |
| bus_addr | output | 7 | Service-bus word address |
| bus_rd | output | 1 | One-cycle read request |
| bus_wr | output | 1 | One-cycle write request |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |

## Verification
A phase register stuck on the wrong side shows up at the next scan. The capture puts the status bits at the wrong end of the register, and the update either issues the wrong strobe or issues none. A busy or error flag that is set or cleared wrongly is visible on the very next Capture-DR or Capture-IR. A stall that is not honoured shows as a stray `bus_rd` or a changed `bus_addr` one cycle after the void update. A wrong field split shows as the wrong address or write data on the first access after the scan.

// File: rtl/svc_scan_pkg.sv
package svc_scan_pkg;
  parameter int ADDR_W = 7;
  parameter int DATA_W = 32;
  parameter int IR_W   = 5;
  localparam int DR_W  = DATA_W + 2;
  localparam int DIR_BIT = DR_W - 1 - ADDR_W;
  localparam logic [IR_W-1:0] SEL_CODE = 5'b10100;

  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_t;
  typedef logic [DR_W-1:0] dr_t;

  // Capture image: status at the top for read data, at the bottom otherwise
  function automatic dr_t capture_word(phase_t ph, logic is_rd, logic err,
                                       logic busy, logic [DATA_W-1:0] rd);
    dr_t w;
    w = '0;
    if (ph == PH_DATA && is_rd) w = {err, busy, rd};
    else begin
      w[1] = err;
      w[0] = busy;
    end
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_field(dr_t w);
    return w[DR_W-1 -: ADDR_W];
  endfunction

  function automatic logic dir_field(dr_t w);
    return w[DIR_BIT];
  endfunction

  function automatic logic [DATA_W-1:0] wdata_field(dr_t w);
    return w[DR_W-1 -: DATA_W];
  endfunction

  function automatic logic [IR_W-1:0] ir_capture(logic prot, logic err, logic busy);
    return {prot, err, busy, 2'b01};
  endfunction
endpackage

// File: rtl/svc_shift_chain.sv
module svc_shift_chain
  import svc_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic shift_evt,
  input  logic tdi,
  input  dr_t  cap_word,
  output dr_t  sr_q,
  output logic tdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr_q <= '0;
    else if (cap_evt)   sr_q <= cap_word;
    else if (shift_evt) sr_q <= {tdi, sr_q[DR_W-1:1]};
  end

  assign tdo = sr_q[0];

  // R3: the capture image appears whole one edge later
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> sr_q == $past(cap_word));

  // R4: each shift moves the chain one place toward bit 0
  p_shift_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !cap_evt) |=> sr_q[DR_W-2:0] == $past(sr_q[DR_W-1:1]));
endmodule

// File: rtl/svc_phase_ctl.sv
module svc_phase_ctl
  import svc_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel,
  input  logic   cap_evt,
  input  logic   upd_evt,
  input  logic   sr_dir,
  input  logic   dir_q,
  input  logic   bus_ack,
  input  logic   bus_err,
  output phase_t phase,
  output logic   busy,
  output logic   err,
  output logic   addr_adv,
  output logic   issue_rd,
  output logic   issue_wr
);
  logic cap_busy_q;
  logic adv_evt;
  logic data_adv;
  logic ack_evt;

  assign adv_evt  = upd_evt && !cap_busy_q;
  assign addr_adv = adv_evt && (phase == PH_ADDR);
  assign data_adv = adv_evt && (phase == PH_DATA);
  assign issue_rd = addr_adv && sr_dir;
  assign issue_wr = data_adv && !dir_q;
  assign ack_evt  = busy && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_ADDR;
      busy       <= 1'b0;
      err        <= 1'b0;
      cap_busy_q <= 1'b0;
    end else begin
      if (!sel)         cap_busy_q <= 1'b0;
      else if (cap_evt) cap_busy_q <= busy;

      if (!sel)         phase <= PH_ADDR;
      else if (adv_evt) phase <= (phase == PH_ADDR) ? PH_DATA : PH_ADDR;

      if (issue_rd || issue_wr) busy <= 1'b1;
      else if (ack_evt)         busy <= 1'b0;

      if (addr_adv)                err <= 1'b0;
      else if (ack_evt && bus_err) err <= 1'b1;
    end
  end

  // R2: deselection forces address mode
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> phase == PH_ADDR);

  // R5: an accepted update flips the phase
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> phase != $past(phase));

  // R9: a void update leaves the phase alone
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && cap_busy_q) |=> $stable(phase));

  // R8: busy persists until the bus answers
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ack) |=> busy);

  // R8: error is sticky until a new address phase
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !addr_adv) |=> err);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_adv |=> !err);
endmodule

// File: rtl/svc_bus_port.sv
module svc_bus_port
  import svc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_adv,
  input  logic              issue_rd,
  input  logic              issue_wr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              dir_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              dir_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      dir_q     <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      bus_rd <= issue_rd;
      bus_wr <= issue_wr;
      if (addr_adv) begin
        bus_addr <= addr_in;
        dir_q    <= dir_in;
      end
      if (issue_wr) bus_wdata <= wdata_in;
      if (busy && bus_ack && dir_q) rdata_q <= bus_rdata;
    end
  end

  // R6: requests are mutually exclusive single-cycle pulses
  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);

  p_rd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> busy);

  // R7: a write request is one cycle long and marks busy
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  p_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> busy);
endmodule

// File: rtl/svc_scan_reg.sv
module svc_scan_reg
  import svc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              prot,
  output logic [IR_W-1:0]   ir_cap,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);
  logic   cap_evt, shift_evt, upd_evt;
  dr_t    sr_q, cap_word;
  phase_t phase;
  logic   busy, err, addr_adv, issue_rd, issue_wr, dir_q;
  logic [DATA_W-1:0] rdata_q;
  logic   sr_bit1_unused;

  assign cap_evt   = sel && cap_dr;
  assign shift_evt = sel && shift_dr;
  assign upd_evt   = sel && upd_dr;

  assign cap_word       = capture_word(phase, dir_q, err, busy, rdata_q);
  assign ir_cap         = ir_capture(prot, err, busy);
  assign sr_bit1_unused = sr_q[1];

  svc_shift_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_evt   (cap_evt),
    .shift_evt (shift_evt),
    .tdi       (tdi),
    .cap_word  (cap_word),
    .sr_q      (sr_q),
    .tdo       (tdo)
  );

  svc_phase_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .cap_evt  (cap_evt),
    .upd_evt  (upd_evt),
    .sr_dir   (dir_field(sr_q)),
    .dir_q    (dir_q),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .phase    (phase),
    .busy     (busy),
    .err      (err),
    .addr_adv (addr_adv),
    .issue_rd (issue_rd),
    .issue_wr (issue_wr)
  );

  svc_bus_port u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_adv  (addr_adv),
    .issue_rd  (issue_rd),
    .issue_wr  (issue_wr),
    .busy      (busy),
    .addr_in   (addr_field(sr_q)),
    .dir_in    (dir_field(sr_q)),
    .wdata_in  (wdata_field(sr_q)),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .dir_q     (dir_q),
    .rdata_q   (rdata_q)
  );

  // R11: no request can follow a deselected cycle's strobes
  p_desel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> !(bus_rd || bus_wr));
endmodule

// File: tb/test_svc_scan_reg.sv
module test_svc_scan_reg;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, sel = 0, cap_dr = 0, shift_dr = 0, upd_dr = 0;
  logic tdi = 0, prot = 0;
  logic tdo, bus_rd, bus_wr;
  logic [4:0]  ir_cap;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 0, bus_err = 0;

  int n_chk = 0, n_fail = 0;
  int lat = 2;
  int rd_cyc = 0, wr_cyc = 0;
  logic [6:0]  seen_addr = '0;
  logic [31:0] seen_wdata = '0;
  logic [31:0] mem [128];
  logic [31:0] exp_mem [128];
  logic exp_err = 0;

  always #(CLK_P/2) clk = ~clk;

  svc_scan_reg i_svc_scan_reg (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .prot(prot), .ir_cap(ir_cap),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  function automatic logic slave_err(logic [6:0] a);
    return a[6:4] == 3'b111;
  endfunction

  function automatic logic [33:0] addr_word(logic [6:0] a, logic rd);
    return {a, rd, 26'b0};
  endfunction

  function automatic logic [33:0] data_word(logic [31:0] d);
    return {d, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [33:0] act,
                     input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobe counters and a simple slave with settable latency
  always @(negedge clk) begin
    if (bus_rd) rd_cyc++;
    if (bus_wr) wr_cyc++;
  end

  initial begin : slave
    forever begin
      @(negedge clk);
      if (bus_rd || bus_wr) begin
        seen_addr = bus_addr;
        if (bus_wr) begin
          seen_wdata = bus_wdata;
          if (!slave_err(bus_addr)) mem[bus_addr] = bus_wdata;
        end
        repeat (lat) @(negedge clk);
        bus_ack = 1; bus_err = slave_err(seen_addr); bus_rdata = mem[seen_addr];
        @(negedge clk);
        bus_ack = 0; bus_err = 0; bus_rdata = '0;
      end
    end
  end

  task automatic scan(input logic [33:0] din, input int nbits, output logic [33:0] dout);
    dout = '0;
    @(negedge clk); cap_dr = 1;
    @(negedge clk); cap_dr = 0; shift_dr = 1;
    for (int i = 0; i < nbits; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; upd_dr = 1;
    @(negedge clk); upd_dr = 0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    logic [33:0] o;
    int w0;
    scan(addr_word(a, 1'b0), 34, o);
    chk(o == {32'b0, exp_err, 1'b0}, "R3 address capture layout", o, {32'b0, exp_err, 1'b0});
    exp_err = 0;
    w0 = wr_cyc;
    scan(data_word(d), 34, o);
    chk(o == 34'b0, "R3 write-data capture layout", o, 34'b0);
    @(negedge clk);
    chk(wr_cyc == w0 + 1, "R7 one write strobe", 34'(wr_cyc - w0), 34'd1);
    chk(seen_addr == a && seen_wdata == d, "R7 write address/data",
        {seen_addr, 27'b0}, {a, 27'b0});
    chk(seen_wdata == d, "R7 write data", {2'b0, seen_wdata}, {2'b0, d});
    if (!slave_err(a)) exp_mem[a] = d;
    exp_err = slave_err(a);
    repeat (lat + 4) @(negedge clk);
  endtask

  task automatic do_read(input logic [6:0] a, input int nb);
    logic [33:0] o, e, m;
    int r0;
    r0 = rd_cyc;
    scan(addr_word(a, 1'b1), 34, o);
    chk(o == {32'b0, exp_err, 1'b0}, "R3 address capture layout", o, {32'b0, exp_err, 1'b0});
    exp_err = 0;
    @(negedge clk);
    chk(rd_cyc == r0 + 1 && seen_addr == a, "R6 read strobe and address",
        {seen_addr, 27'(rd_cyc - r0)}, {a, 27'd1});
    repeat (lat + 4) @(negedge clk);
    scan(34'b0, nb, o);
    e = {slave_err(a), 1'b0, exp_mem[a]};
    m = (nb >= 34) ? '1 : ((34'd1 << nb) - 34'd1);
    chk((o & m) == (e & m), nb < 34 ? "R10 early-ended read data" : "R3 read-data capture",
        o & m, e & m);
    exp_err = slave_err(a);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [33:0] o;
    logic [6:0]  a2;
    int r0, w0;
    void'($urandom(32'h1ACE));
    for (int i = 0; i < 128; i++) begin
      mem[i] = (i * 32'h01010101) ^ 32'hA5A5_0000;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ir_cap == 5'b00001, "R1 reset IR capture", {29'b0, ir_cap}, 34'd1);
    chk(!bus_rd && !bus_wr && bus_addr == 0, "R2 reset bus idle",
        {25'b0, bus_addr, bus_rd, bus_wr}, 34'b0);
    prot = 1;
    @(negedge clk);
    chk(ir_cap == 5'b10001, "R1 protection bit", {29'b0, ir_cap}, 34'h11);
    sel = 1;

    // R11: strobes while deselected
    sel = 0;
    r0 = rd_cyc; w0 = wr_cyc;
    scan(addr_word(7'h15, 1'b1), 34, o);
    repeat (3) @(negedge clk);
    chk(rd_cyc == r0 && wr_cyc == w0 && bus_addr == 0, "R11 deselected strobes ignored",
        {25'b0, bus_addr, 2'(rd_cyc - r0)}, 34'b0);
    sel = 1;

    // directed: full write then read back, error address
    do_write(7'h05, 32'hDEAD_BEEF);
    do_read(7'h05, 34);
    do_write(7'h72, 32'h1234_5678);
    chk(ir_cap[3] == 1'b1, "R1 error bit in IR capture", {29'b0, ir_cap}, {29'b0, 5'b11001});
    do_read(7'h72, 34);
    do_read(7'h06, 34);

    // random traffic
    for (int k = 0; k < 30; k++) begin
      logic [6:0] a;
      logic [31:0] d;
      lat = $urandom_range(0, 6);
      a = 7'($urandom_range(0, 127));
      d = $urandom;
      if ($urandom_range(0, 1) == 1) do_write(a, d);
      else do_read(a, 34);
    end
    lat = 2;

    // R9: busy during a write makes the following address scan void
    lat = 25;
    scan(addr_word(7'h11, 1'b0), 34, o);
    chk(o[1:0] == {exp_err, 1'b0}, "R3 status before stall", o, {32'b0, exp_err, 1'b0});
    exp_err = 0;
    scan(data_word(32'hCAFE_F00D), 34, o);
    exp_mem[7'h11] = 32'hCAFE_F00D;
    chk(ir_cap[2] == 1'b1, "R1 busy bit in IR capture", {29'b0, ir_cap}, 34'h15);
    r0 = rd_cyc;
    a2 = 7'h2A;
    scan(addr_word(a2, 1'b1), 34, o);
    chk(o[1:0] == 2'b01, "R8 busy seen while write pending", o, 34'b01);
    repeat (2) @(negedge clk);
    chk(rd_cyc == r0 && bus_addr == 7'h11, "R9 void update issues nothing",
        {25'b0, bus_addr, 2'(rd_cyc - r0)}, {25'b0, 7'h11, 2'b0});
    repeat (lat + 4) @(negedge clk);
    lat = 2;
    do_read(a2, 34);

    // R9: busy during a read keeps the data phase
    lat = 25;
    scan(addr_word(7'h33, 1'b1), 34, o);
    chk(o[1:0] == {exp_err, 1'b0}, "R3 status before read stall", o, {32'b0, exp_err, 1'b0});
    exp_err = 0;
    scan(34'b0, 34, o);
    chk(o[33:32] == 2'b01, "R8 busy at top of read-data capture", o, {2'b01, 32'b0});
    repeat (lat + 4) @(negedge clk);
    scan(34'b0, 34, o);
    chk(o == {2'b00, exp_mem[7'h33]}, "R9 read phase kept after void scan", o,
        {2'b00, exp_mem[7'h33]});
    lat = 2;
    do_write(7'h34, 32'h0F0F_1234);

    // R10: early-ended read then a normal access
    do_read(7'h05, 8);
    do_read(7'h34, 34);

    // R2: deselect in data phase, reselect starts in address phase
    r0 = rd_cyc;
    scan(addr_word(7'h40, 1'b1), 34, o);
    exp_err = 0;
    repeat (lat + 4) @(negedge clk);
    sel = 0;
    repeat (2) @(negedge clk);
    sel = 1;
    do_read(7'h41, 34);
    chk(rd_cyc == r0 + 2, "R2 address phase after reselect", 34'(rd_cyc - r0), 34'd2);

    // R4: capture then 34 shifts walks the word out LSB first
    scan(addr_word(7'h05, 1'b1), 34, o);
    exp_err = 0;
    repeat (lat + 4) @(negedge clk);
    scan(34'b0, 34, o);
    chk(o == {2'b00, exp_mem[7'h05]}, "R4 bit order of read word", o, {2'b00, exp_mem[7'h05]});

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule